// File: doc/BRIEF.md
# Core-Local Machine Timer

This block keeps the machine time base and the per-hart timer deadlines for a small multi-hart processor cluster. It holds a single 64-bit time counter. That counter advances by one on every clock cycle in which the tick-enable input is high. The block also holds one 64-bit deadline (compare) register for each hart. Each hart gets a level-sensitive timer interrupt line, which is high whenever the counter has reached or passed that hart's deadline.

Software reaches every register through a flat 32-bit register port with an address, a write enable, write data and combinational read data. Each 64-bit register appears as two 32-bit words, with the low word at the lower address. Deadlines begin at offset 0x4000 from the block base and take 8 bytes per hart. The counter sits at offset 0xBFF8. The base is a parameter and must be a multiple of four.

Top module: `mtu_timer`

## Requirements
- R1: The deadline of hart N has its low word at base+0x4000+8*N and its high word at base+0x4004+8*N, for N below NUM_HARTS. A write reaches only that hart's register.
- R2: The time counter has its low word at base+0xBFF8 and its high word at base+0xBFFC.
- R3: After reset the counter reads zero, every deadline word reads 0xFFFFFFFF and every interrupt line is low.
- R4: The counter increases by exactly one at each clock edge where tick_en is high and no counter write occurs. It is unchanged when tick_en is low.
- R5: The counter carries from the low word into the high word and wraps from all ones to zero.
- R6: A write to one counter word replaces only that word, and the other word holds its value. In that cycle the write wins over the increment, so no increment happens.
- R7: timer_irq[N] is high exactly while the unsigned counter value is greater than or equal to deadline N, including equality. It drops as soon as a larger deadline is written.
- R8: Reads return zero at any unmapped address: below the base, beyond the map, not word aligned, or a deadline slot at or above NUM_HARTS. Writes to those addresses change no register.
- R9: Read data follows the address within the same cycle. A write becomes visible only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Time base: counter advances in cycles where this is high |
| reg_addr | input | ADDR_W | Byte address of the register word |
| reg_we | input | 1 | Write strobe for the addressed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| timer_irq | output | NUM_HARTS | Per-hart machine timer interrupt level |

## Verification
The counter can be told to increment by tick_en and be written by software in the same cycle. The bench provokes this by holding tick_en high during one write to the low word and one write to the high word. It expects the written word to appear exactly and the other word to keep its value, with no increment in that cycle. The second collision is a deadline crossing. The bench ticks the counter onto the deadline value and checks that the interrupt is low one cycle before equality and high at equality. A later deadline write then drops the line in the cycle after that write.

// File: rtl/mtu_pkg.sv
package mtu_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned TIME_W = 64;

  typedef struct packed {
    logic hit_time;
    logic hit_cmp;
    logic upper;
  } mtu_sel_t;

  function automatic logic mtu_due(input logic [TIME_W-1:0] now,
                                   input logic [TIME_W-1:0] deadline);
    return now >= deadline;
  endfunction

  function automatic logic [TIME_W-1:0] mtu_merge(input logic [TIME_W-1:0] old,
                                                  input logic [WORD_W-1:0] word,
                                                  input logic upper);
    logic [TIME_W-1:0] res;
    res = old;
    if (upper) res[TIME_W-1:WORD_W] = word;
    else       res[WORD_W-1:0]      = word;
    return res;
  endfunction

  function automatic logic [WORD_W-1:0] mtu_half(input logic [TIME_W-1:0] val,
                                                 input logic upper);
    return upper ? val[TIME_W-1:WORD_W] : val[WORD_W-1:0];
  endfunction

endpackage

// File: rtl/mtu_decode.sv
module mtu_decode
  import mtu_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W = 32,
  parameter bit [ADDR_W-1:0] BASE_ADDR = '0,
  localparam int unsigned HIDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output mtu_sel_t          sel,
  output logic [HIDX_W-1:0] hart
);

  localparam logic [ADDR_W-1:0] CMP_OFF  = ADDR_W'(32'h4000);
  localparam logic [ADDR_W-1:0] CMP_END  = ADDR_W'(32'h4000 + 8 * NUM_HARTS);
  localparam logic [ADDR_W-1:0] TIME_OFF = ADDR_W'(32'hBFF8);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] rel;
  logic              in_win;
  logic              aligned;

  always_comb begin
    off     = addr - BASE_ADDR;
    rel     = off - CMP_OFF;
    in_win  = addr >= BASE_ADDR;
    aligned = off[1:0] == 2'b00;
    sel.upper    = off[2];
    sel.hit_time = in_win && aligned && ((off >> 3) == (TIME_OFF >> 3));
    sel.hit_cmp  = in_win && aligned && (off >= CMP_OFF) && (off < CMP_END);
    hart         = HIDX_W'(rel >> 3);
  end

endmodule

// File: rtl/mtu_counter.sv
module mtu_counter
  import mtu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  output logic [TIME_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)              count <= '0;
    else if (wr_lo || wr_hi) count <= mtu_merge(count, wdata, wr_hi);
    else if (tick_en)        count <= count + TIME_W'(1);
  end

endmodule

// File: rtl/mtu_cmp_slot.sv
module mtu_cmp_slot
  import mtu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              upper,
  input  logic [WORD_W-1:0] wdata,
  input  logic [TIME_W-1:0] now,
  output logic [TIME_W-1:0] deadline,
  output logic              irq
);

  always_ff @(posedge clk) begin
    if (!rst_n)     deadline <= '1;
    else if (wr_en) deadline <= mtu_merge(deadline, wdata, upper);
  end

  assign irq = mtu_due(now, deadline);

endmodule

// File: rtl/mtu_timer.sv
module mtu_timer
  import mtu_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W = 32,
  parameter bit [ADDR_W-1:0] BASE_ADDR = ADDR_W'(32'h0200_0000)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_we,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic [NUM_HARTS-1:0] timer_irq
);

  localparam int unsigned HIDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  mtu_sel_t          sel;
  logic [HIDX_W-1:0] hart;
  logic              map_hit;
  logic              time_wr_lo;
  logic              time_wr_hi;
  logic [NUM_HARTS-1:0] cmp_wr;
  logic [TIME_W-1:0] mtime_q;
  logic [TIME_W-1:0] cmp_q [NUM_HARTS];

  mtu_decode #(
    .NUM_HARTS(NUM_HARTS),
    .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .addr(reg_addr),
    .sel(sel),
    .hart(hart)
  );

  assign map_hit    = sel.hit_time || sel.hit_cmp;
  assign time_wr_lo = reg_we && sel.hit_time && !sel.upper;
  assign time_wr_hi = reg_we && sel.hit_time && sel.upper;

  mtu_counter u_counter (
    .clk(clk),
    .rst_n(rst_n),
    .tick_en(tick_en),
    .wr_lo(time_wr_lo),
    .wr_hi(time_wr_hi),
    .wdata(reg_wdata),
    .count(mtime_q)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    assign cmp_wr[h] = reg_we && sel.hit_cmp && (hart == HIDX_W'(h));

    mtu_cmp_slot u_slot (
      .clk(clk),
      .rst_n(rst_n),
      .wr_en(cmp_wr[h]),
      .upper(sel.upper),
      .wdata(reg_wdata),
      .now(mtime_q),
      .deadline(cmp_q[h]),
      .irq(timer_irq[h])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (sel.hit_time)     reg_rdata = mtu_half(mtime_q, sel.upper);
    else if (sel.hit_cmp) reg_rdata = mtu_half(cmp_q[hart], sel.upper);
  end

endmodule

// File: rtl/mtu_timer_chk.sv
module mtu_timer_chk #(
  parameter int unsigned NUM_HARTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick_en,
  input logic                 reg_we,
  input logic [31:0]          reg_wdata,
  input logic [31:0]          reg_rdata,
  input logic                 map_hit,
  input logic                 time_wr_lo,
  input logic                 time_wr_hi,
  input logic [NUM_HARTS-1:0] cmp_wr,
  input logic [63:0]          mtime_q,
  input logic [NUM_HARTS-1:0] timer_irq
);

  logic time_wr;
  assign time_wr = time_wr_lo || time_wr_hi;

  AST_CMP_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmp_wr) && !(time_wr && (cmp_wr != '0))); // R1

  AST_TIME_INC: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !time_wr |=> mtime_q == $past(mtime_q) + 64'd1); // R4

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !time_wr |=> $stable(mtime_q)); // R4

  AST_TIME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !time_wr && (mtime_q == '1) |=> mtime_q == '0); // R5

  AST_WR_LO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr_lo |=> (mtime_q[31:0] == $past(reg_wdata)) &&
                   (mtime_q[63:32] == $past(mtime_q[63:32]))); // R6

  AST_WR_HI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr_hi |=> (mtime_q[63:32] == $past(reg_wdata)) &&
                   (mtime_q[31:0] == $past(mtime_q[31:0]))); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !map_hit |-> reg_rdata == 32'd0); // R8

  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && !map_hit && !tick_en |=> $stable(mtime_q)); // R8

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_irq
    AST_IRQ_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      timer_irq[h] && !cmp_wr[h] && !time_wr && (mtime_q != '1) |=> timer_irq[h]); // R7
  end

endmodule

bind mtu_timer mtu_timer_chk #(.NUM_HARTS(NUM_HARTS)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .tick_en(tick_en),
  .reg_we(reg_we),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .map_hit(map_hit),
  .time_wr_lo(time_wr_lo),
  .time_wr_hi(time_wr_hi),
  .cmp_wr(cmp_wr),
  .mtime_q(mtime_q),
  .timer_irq(timer_irq)
);

// File: tb/test_mtu_timer.sv
module test_mtu_timer;

  localparam int unsigned NH = 4;
  localparam logic [31:0] BASE = 32'h0200_0000;
  localparam logic [31:0] TLO  = BASE + 32'hBFF8;
  localparam logic [31:0] THI  = BASE + 32'hBFFC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic [31:0]   reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NH-1:0] timer_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mtu_timer #(.NUM_HARTS(NH), .ADDR_W(32), .BASE_ADDR(BASE)) i_mtu_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .timer_irq(timer_irq)
  );

  function automatic logic [31:0] cmp_lo(input int n);
    return BASE + 32'h4000 + 32'(8 * n);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(TLO, v); check("R3 R2 time low", 64'(v), 64'd0);
    rd(THI, v); check("R3 R2 time high", 64'(v), 64'd0);
    for (int n = 0; n < NH; n++) begin
      rd(cmp_lo(n), v);      check("R3 R1 deadline low", 64'(v), 64'hFFFF_FFFF);
      rd(cmp_lo(n) + 4, v);  check("R3 R1 deadline high", 64'(v), 64'hFFFF_FFFF);
    end
    check("R3 irq idle", 64'(timer_irq), 64'd0);
  endtask

  task automatic t_tick;
    logic [31:0] v;
    ticks(10);
    rd(TLO, v); check("R4 ten ticks", 64'(v), 64'd10);
    repeat (5) @(negedge clk);
    rd(TLO, v); check("R4 hold without tick", 64'(v), 64'd10);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(THI, 32'hFFFF_FFFF); wr(TLO, 32'hFFFF_FFFE);
    ticks(3);
    rd(TLO, v); check("R5 wrap low", 64'(v), 64'd1);
    rd(THI, v); check("R5 wrap high", 64'(v), 64'd0);
    wr(THI, 32'd5); wr(TLO, 32'hFFFF_FFFF);
    ticks(1);
    rd(TLO, v); check("R5 carry low", 64'(v), 64'd0);
    rd(THI, v); check("R5 carry high", 64'(v), 64'd6);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    wr(THI, 32'd7); wr(TLO, 32'd3);
    @(negedge clk);
    tick_en = 1'b1; reg_addr = TLO; reg_we = 1'b1; reg_wdata = 32'h100;
    @(negedge clk);
    tick_en = 1'b0; reg_we = 1'b0;
    rd(TLO, v); check("R6 low write beats tick", 64'(v), 64'h100);
    rd(THI, v); check("R6 high kept", 64'(v), 64'd7);
    @(negedge clk);
    tick_en = 1'b1; reg_addr = THI; reg_we = 1'b1; reg_wdata = 32'd9;
    @(negedge clk);
    tick_en = 1'b0; reg_we = 1'b0;
    rd(THI, v); check("R6 high write beats tick", 64'(v), 64'd9);
    rd(TLO, v); check("R6 low kept no increment", 64'(v), 64'h100);
  endtask

  task automatic t_comb_read;
    logic [31:0] v;
    @(negedge clk);
    reg_addr = cmp_lo(2); reg_we = 1'b1; reg_wdata = 32'h0000_ABCD;
    #1;
    check("R9 old value before edge", 64'(reg_rdata), 64'hFFFF_FFFF);
    @(negedge clk);
    reg_we = 1'b0;
    rd(cmp_lo(2), v); check("R9 new value after edge", 64'(v), 64'hABCD);
    rd(cmp_lo(2) + 4, v); check("R1 other half kept", 64'(v), 64'hFFFF_FFFF);
  endtask

  task automatic t_irq;
    wr(THI, 32'd0); wr(TLO, 32'd50);
    wr(cmp_lo(0) + 4, 32'd0); wr(cmp_lo(0), 32'd60);
    check("R7 below deadline", 64'(timer_irq[0]), 64'd0);
    ticks(9);
    check("R7 one before deadline", 64'(timer_irq[0]), 64'd0);
    ticks(1);
    check("R7 at deadline", 64'(timer_irq[0]), 64'd1);
    check("R7 other harts quiet", 64'(timer_irq[3:1]), 64'd0);
    wr(cmp_lo(0), 32'd100);
    check("R7 cleared by later deadline", 64'(timer_irq[0]), 64'd0);
    wr(cmp_lo(1) + 4, 32'h8000_0000); wr(cmp_lo(1), 32'd0);
    wr(THI, 32'h7FFF_FFFF);
    check("R7 unsigned below", 64'(timer_irq[1]), 64'd0);
    wr(THI, 32'h8000_0001);
    check("R7 unsigned above", 64'(timer_irq[1]), 64'd1);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(THI, 32'd0); wr(TLO, 32'd77);
    wr(cmp_lo(NH), 32'h55);
    rd(cmp_lo(NH), v);     check("R8 absent hart low", 64'(v), 64'd0);
    rd(cmp_lo(NH) + 4, v); check("R8 absent hart high", 64'(v), 64'd0);
    rd(cmp_lo(0), v); check("R8 hart0 untouched", 64'(v), 64'd100);
    rd(cmp_lo(1), v); check("R8 hart1 untouched", 64'(v), 64'd0);
    rd(cmp_lo(2), v); check("R8 hart2 untouched", 64'(v), 64'hABCD);
    rd(cmp_lo(3), v); check("R8 hart3 untouched", 64'(v), 64'hFFFF_FFFF);
    wr(cmp_lo(0) + 2, 32'h1234);
    rd(cmp_lo(0), v); check("R8 misaligned write ignored", 64'(v), 64'd100);
    rd(cmp_lo(0) + 2, v); check("R8 misaligned read zero", 64'(v), 64'd0);
    rd(BASE - 8, v); check("R8 below base", 64'(v), 64'd0);
    rd(BASE + 32'hC000, v); check("R8 beyond map", 64'(v), 64'd0);
    rd(BASE, v); check("R8 hole at base", 64'(v), 64'd0);
    wr(BASE + 32'hBFFA, 32'hDEAD);
    rd(TLO, v); check("R8 time untouched", 64'(v), 64'd77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tick();
    t_wrap();
    t_priority();
    t_comb_read();
    t_irq();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule